// File: doc/BRIEF.md
# Fine-Adjust PTP Time Counter

This block keeps a precision timestamp as a 32-bit seconds count and a 30-bit nanoseconds count. The PTP reference clock steps both counts. Two update modes are available. In coarse mode, a programmed nanosecond increment is added to the time on every reference clock cycle. In fine mode, a 32-bit frequency-trim addend is summed into a 32-bit phase accumulator each cycle. The increment is applied only on the cycles where that sum carries out. This lets the clock rate be tuned in steps far smaller than one increment.

Software sets the mode, the increment and the addend through a plain register write port. A separate time-load port sets the current time. Both counts are visible at all times on the outputs. A typical fine-mode setup uses an increment of twice the reference period in nanoseconds and an addend of 2^31. Examples are 80 ns at 25 MHz, 10 ns at 200 MHz and 400 ns at 5 MHz. The addend is then trimmed to track a remote master. All pins are control and status pins with no flow control: a write or load is taken on the edge where its strobe is high.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, the time reads 0 s / 0 ns, the mode is coarse, the increment is 0 and the accumulator is 0, so the time holds at zero until it is programmed.
- R2: In coarse mode (mode register bit 0 = 0), every clock edge adds the increment to the nanoseconds, and the accumulator is left untouched.
- R3: In fine mode (mode register bit 0 = 1), every edge replaces the accumulator with the low 32 bits of accumulator + addend. The increment is added to the nanoseconds only on edges where bit 32 of that unsigned sum is 1.
- R4: In fine mode with an addend of 2^31, the nanoseconds advance by the increment on exactly one edge of every two.
- R5: In fine mode with an addend of 0, the time does not advance.
- R6: When the nanoseconds would reach or pass 1,000,000,000, that value is subtracted and the seconds count is incremented on the same edge (the seconds wrap modulo 2^32). The nanoseconds always stay below 1,000,000,000.
- R7: An edge with `load_en` high loads `load_sec` and `load_ns` as the time and clears the accumulator. The load takes priority over that edge's normal advance.
- R8: `cfg_we` with `cfg_addr` 0 writes the mode (wdata bit 0), address 1 writes the increment (wdata bits 8:0) and address 2 writes the addend (wdata bits 31:0). A write at address 3 changes nothing. A written value first governs the edge after the write, and a write leaves the accumulator contents unchanged.
- R9: The increment is 9 bits wide, so 400 ns (fine mode at a 5 MHz reference) is held and applied exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PTP reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 increment, 2 addend |
| cfg_wdata | input | 32 | Register write data |
| load_en | input | 1 | Time-load strobe |
| load_sec | input | 32 | Seconds value to load |
| load_ns | input | 30 | Nanoseconds value to load (below 1e9) |
| time_sec | output | 32 | Current seconds |
| time_ns | output | 30 | Current nanoseconds |

## Verification
The assertions assume that every loaded nanoseconds value is below 1,000,000,000. Under that assumption, the sub-second range check and the single-step rollover check hold on every edge. They also assume that reset is applied before any strobe is used. The stimulus keeps to these assumptions: random loads draw their nanoseconds modulo 1e9, and the directed rollover cases load values just under the limit. Random register writes may use any address and any data, including the ignored address 3 and increments up to 511.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  typedef enum logic {
    MODE_COARSE = 1'b0,
    MODE_FINE   = 1'b1
  } upd_mode_e;

  localparam logic [1:0] REG_MODE   = 2'd0;
  localparam logic [1:0] REG_INCR   = 2'd1;
  localparam logic [1:0] REG_ADDEND = 2'd2;
endpackage

// File: rtl/ptp_tc_cfg.sv
module ptp_tc_cfg
  import ptp_tc_pkg::*;
#(
  parameter int INCR_W = 9,
  parameter int ACC_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output upd_mode_e         mode,
  output logic [INCR_W-1:0] incr,
  output logic [ACC_W-1:0]  addend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_COARSE;
      incr   <= '0;
      addend <= '0;
    end else if (we) begin
      case (addr)
        REG_MODE:   mode   <= upd_mode_e'(wdata[0]);
        REG_INCR:   incr   <= wdata[INCR_W-1:0];
        REG_ADDEND: addend <= wdata[ACC_W-1:0];
        default:    ;
      endcase
    end
  end

  assert_addend_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == REG_ADDEND) |=> addend == $past(wdata[ACC_W-1:0]));
  assert_incr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == REG_INCR) |=> incr == $past(wdata[INCR_W-1:0]));
  assert_unused_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd3) |=> ($stable(incr) && $stable(addend) && $stable(mode)));
endmodule

// File: rtl/ptp_tc_phase.sv
module ptp_tc_phase #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [ACC_W-1:0] addend,
  output logic             carry
);
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_q;

  assign sum   = {1'b0, acc_q} + {1'b0, addend};
  assign carry = run & sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (run)   acc_q <= sum[ACC_W-1:0];
  end

  assert_acc_hold_coarse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(acc_q));
  assert_acc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc_q == '0);
  assert_zero_addend_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addend == '0) |-> !carry);
  assert_half_addend_alternates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && addend == {1'b1, {(ACC_W-1){1'b0}}}) |=>
      (run && !clear && $stable(addend)) |-> (carry != $past(carry)));
endmodule

// File: rtl/ptp_tc_clock.sv
module ptp_tc_clock #(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int INCR_W     = 9,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [INCR_W-1:0] incr,
  input  logic              load,
  input  logic [SEC_W-1:0]  load_sec,
  input  logic [NS_W-1:0]   load_ns,
  output logic [SEC_W-1:0]  sec_q,
  output logic [NS_W-1:0]   ns_q
);
  localparam logic [NS_W:0] NS_LIMIT = (NS_W+1)'(NS_PER_SEC);

  logic [NS_W:0]   ns_sum;
  logic            wrap;
  logic [NS_W-1:0] ns_next;

  always_comb begin
    ns_sum  = {1'b0, ns_q} + (step_en ? (NS_W+1)'(incr) : '0);
    wrap    = (ns_sum >= NS_LIMIT);
    ns_next = wrap ? NS_W'(ns_sum - NS_LIMIT) : ns_sum[NS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (load) begin
      sec_q <= load_sec;
      ns_q  <= load_ns;
    end else begin
      ns_q <= ns_next;
      if (wrap) sec_q <= sec_q + 1'b1;
    end
  end

  assert_ns_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ns_q} < NS_LIMIT));
  assert_sec_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec_q == $past(load_sec) && ns_q == $past(load_ns)));
  assert_no_step_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_en) |=> ($stable(sec_q) && $stable(ns_q)));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int INCR_W     = 9,
  parameter int ACC_W      = 32,
  parameter int DATA_W     = 32,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              load_en,
  input  logic [SEC_W-1:0]  load_sec,
  input  logic [NS_W-1:0]   load_ns,
  output logic [SEC_W-1:0]  time_sec,
  output logic [NS_W-1:0]   time_ns
);
  upd_mode_e         mode;
  logic [INCR_W-1:0] incr;
  logic [ACC_W-1:0]  addend;
  logic              fine_run;
  logic              carry;
  logic              step_en;

  ptp_tc_cfg #(.INCR_W(INCR_W), .ACC_W(ACC_W), .DATA_W(DATA_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode), .incr(incr), .addend(addend)
  );

  assign fine_run = (mode == MODE_FINE) && !load_en;

  ptp_tc_phase #(.ACC_W(ACC_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .run(fine_run), .clear(load_en),
    .addend(addend), .carry(carry)
  );

  assign step_en = (mode == MODE_FINE) ? carry : 1'b1;

  ptp_tc_clock #(.SEC_W(SEC_W), .NS_W(NS_W), .INCR_W(INCR_W), .NS_PER_SEC(NS_PER_SEC)) clock_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .incr(incr), .load(load_en),
    .load_sec(load_sec), .load_ns(load_ns), .sec_q(time_sec), .ns_q(time_ns)
  );

  assert_coarse_every_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_COARSE && !load_en && incr != '0) |=> !$stable(time_ns));
  assert_reset_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n)) |-> (time_sec == '0));
endmodule

// File: tb/ptp_time_counter_tb_top.sv
module ptp_time_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint NS_SEC = 1_000_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        load_en = 1'b0;
  logic [31:0] load_sec = '0;
  logic [29:0] load_ns = '0;
  logic [31:0] time_sec;
  logic [29:0] time_ns;

  int checks = 0;
  int errors = 0;

  // bench model state
  bit          m_fine;
  int unsigned m_incr;
  longint unsigned m_add, m_acc, m_sec, m_ns;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_time_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .load_en(load_en), .load_sec(load_sec), .load_ns(load_ns),
    .time_sec(time_sec), .time_ns(time_ns)
  );

  function automatic longint unsigned step_amount(bit fine, int unsigned inc,
                                                  longint unsigned acc, longint unsigned add);
    if (!fine) return inc;
    return ((acc + add) >> 32) != 0 ? inc : 0;
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    longint unsigned st;
    if (load_en) begin
      m_sec = load_sec; m_ns = load_ns; m_acc = 0;
    end else begin
      st = step_amount(m_fine, m_incr, m_acc, m_add);
      if (m_fine) m_acc = (m_acc + m_add) & 64'hFFFF_FFFF;
      m_ns = m_ns + st;
      if (m_ns >= NS_SEC) begin
        m_ns = m_ns - NS_SEC;
        m_sec = (m_sec + 1) & 64'hFFFF_FFFF;
      end
    end
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: m_fine = cfg_wdata[0];
        2'd1: m_incr = cfg_wdata[8:0];
        2'd2: m_add  = cfg_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic tick(string req, bit we = 0, logic [1:0] a = 0, logic [31:0] d = 0,
                      bit ld = 0, logic [31:0] ls = 0, logic [29:0] ln = 0);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    load_en = ld; load_sec = ls; load_ns = ln;
    @(posedge clk);
    model_edge();
    #1;
    cfg_we = 0; load_en = 0;
    check({req, " sec"}, time_sec, m_sec);
    check({req, " ns"}, time_ns, m_ns);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint unsigned base;
    void'($urandom(32'd2024));
    m_fine = 0; m_incr = 0; m_add = 0; m_acc = 0; m_sec = 0; m_ns = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state holds at zero
    for (int i = 0; i < 3; i++) tick("R1");
    check("R1 reset ns", time_ns, 0);

    // R8: increment write first counts on the following edge
    tick("R8", 1, 2'd1, 32'd10);
    check("R8 no effect on write edge", time_ns, 0);
    tick("R2");
    check("R2 coarse +10", time_ns, 10);
    for (int i = 0; i < 5; i++) tick("R2");
    check("R2 coarse after 6 edges", time_ns, 60);
    // R8: address 3 ignored
    tick("R8", 1, 2'd3, 32'hFFFF_FFFF);
    tick("R8");
    check("R8 addr3 ignored", time_ns, 80);

    // R4: fine mode, addend 2^31, incr 80
    tick("R8", 1, 2'd2, 32'h8000_0000);
    tick("R8", 1, 2'd1, 32'd80);
    tick("R8", 1, 2'd0, 32'd1);
    base = time_ns;
    for (int i = 0; i < 4; i++) tick("R4");
    check("R4 two steps in four edges", time_ns - base, 160);
    base = time_ns;
    tick("R4");
    tick("R4");
    check("R4 one step in two edges", time_ns - base, 80);

    // R5: addend 0 freezes time
    tick("R5", 1, 2'd2, 32'd0);
    base = time_ns;
    for (int i = 0; i < 10; i++) tick("R5");
    check("R5 frozen", time_ns, base);

    // R3: quarter addend -> one step every four edges
    tick("R3", 1, 2'd2, 32'h4000_0000);
    tick("R3", 0, 0, 0, 1, 32'd7, 30'd0);
    for (int i = 0; i < 8; i++) tick("R3");
    check("R3 quarter addend", time_ns, 160);
    tick("R3", 1, 2'd2, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) tick("R3");

    // R7: load clears the accumulator and wins over advance
    tick("R7", 1, 2'd2, 32'h8000_0000);
    tick("R7");
    tick("R7", 0, 0, 0, 1, 32'd100, 30'd500);
    check("R7 load sec", time_sec, 100);
    check("R7 load ns", time_ns, 500);
    tick("R7");
    check("R7 acc cleared, no carry", time_ns, 500);
    tick("R7");
    check("R7 first carry", time_ns, 580);

    // R6: rollover in coarse mode, including seconds wrap
    tick("R6", 1, 2'd0, 32'd0);
    tick("R6", 1, 2'd1, 32'd10);
    tick("R6", 0, 0, 0, 1, 32'd5, 30'd999_999_990);
    tick("R6");
    check("R6 sec roll", time_sec, 6);
    check("R6 ns roll", time_ns, 0);
    tick("R6", 1, 2'd1, 32'd7);
    tick("R6", 0, 0, 0, 1, 32'hFFFF_FFFF, 30'd999_999_995);
    tick("R6");
    check("R6 sec wrap", time_sec, 0);
    check("R6 ns remainder", time_ns, 2);

    // R9: 400 ns increment at addend 2^31
    tick("R9", 1, 2'd1, 32'd400);
    tick("R9", 1, 2'd2, 32'h8000_0000);
    tick("R9", 1, 2'd0, 32'd1);
    tick("R9", 0, 0, 0, 1, 32'd0, 30'd0);
    for (int i = 0; i < 4; i++) tick("R9");
    check("R9 400ns steps", time_ns, 800);

    // R8: addend change keeps accumulator phase
    tick("R8");
    tick("R8", 1, 2'd2, 32'hC000_0000);
    for (int i = 0; i < 6; i++) tick("R8");

    // R3: random mix, model-checked every edge
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 100;
      if (r < 4)
        tick("R3", 0, 0, 0, 1, $urandom, 30'($urandom % 1_000_000_000));
      else if (r < 14)
        tick("R3", 1, 2'($urandom), (($urandom % 4) == 0) ? 32'h8000_0000 : $urandom);
      else
        tick("R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule